// File: doc/BRIEF.md
# UART Receive Character Queue with Threshold and Timeout Interrupts

This block is the buffer that sits between a UART's receive shift stage and the bus. Each completed character arrives as a one-cycle strobe with its data byte and the configured character length (5 to 8 bits). The block masks off the unused upper bits and keeps up to 16 characters in first-in, first-out order. A bus read strobe removes the oldest character, which is shown on the read data port beforehand. Software cannot see the storage itself. It sees only the head character, a not-empty flag, a sticky overrun flag and the interrupt outputs.

Two interrupt causes are produced. The data-ready cause is raised when the fill level reaches a trigger threshold. The threshold is picked by a 2-bit select that gives 1, 4, 8 or 14 characters. The idle-timeout cause is raised when some characters sit below the threshold and no push or pop has happened for about three and a half character times. Those character times are measured with a bit-time tick input. Both causes reach the interrupt line and the encoded cause field only while the interrupt enable input is high.

The write side has no ready signal, because a serial receiver cannot be stalled. A character that arrives while the queue is full is dropped and sets the overrun flag. The read side is also a plain strobe: the data port is valid whenever the not-empty flag is high, and a pop while empty does nothing.

Top module: `uart_rx_queue`

## Requirements
- R1: The queue holds up to 16 characters in arrival order. A character strobed in while 16 are held (with no pop in the same cycle) is discarded, and the held contents are unchanged.
- R2: `rd_data` shows the oldest held character, and a `rd_pop` pulse removes it, so successive pops return successive characters. While the queue is empty, `rd_data` is 0, `rx_nonempty` is 0 and a pop has no effect.
- R3: `ch_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Stored bits at and above the character length are forced to 0, and bit 0 is the first-received bit.
- R4: `trig_sel` codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 characters. The data-ready cause is pending while the fill level is greater than or equal to the threshold.
- R5: `irq` is high only while `irq_en` is 1 and a cause is pending. While `irq_en` is 0, `irq_id` reads 0.
- R6: `irq_id` is 2 for data-ready, 6 for idle-timeout and 0 when nothing is pending. Data-ready wins when both causes apply.
- R7: Idle-timeout is pending when 0 < fill < threshold and floor(7*(L+2)/2) bit ticks have passed since the last push or pop, where L is the character length in bits (35 ticks for 8 bits). Any push or pop clears it and restarts the count.
- R8: `overrun` is set by a discarded character and stays set until an `ovr_clr` pulse. If a discard and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | One-cycle strobe: a completed character is on `in_data` |
| in_data | input | 8 | Received character, bit 0 first-received |
| ch_len | input | 2 | Character length code (5 + code bits) |
| bit_tick | input | 1 | One pulse per serial bit time |
| trig_sel | input | 2 | Threshold select: 1, 4, 8, 14 characters |
| irq_en | input | 1 | Receive interrupt enable |
| rd_pop | input | 1 | Bus read strobe: remove the head character |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| rd_data | output | 8 | Oldest held character, 0 when empty |
| rx_nonempty | output | 1 | At least one character held |
| overrun | output | 1 | Sticky flag: a character was discarded |
| irq | output | 1 | Receive interrupt request |
| irq_id | output | 3 | Pending cause: 0 none, 2 data-ready, 6 idle-timeout |

## Verification
A wrong read or write pointer shows on `rd_data` at the first pop after the fault, as a character out of order or a repeated one. A wrong fill count shows within one cycle as `irq_id` switching to 2 at the wrong threshold, or as `rx_nonempty` clearing too early or too late during a drain. A timeout counter that fails to restart, or that counts to the wrong limit, shows as code 6 appearing one tick early or late, or not going away after a pop. A wrong length mask shows on the first character read back.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned LEN_MIN = 5;

  typedef enum logic [2:0] {
    IID_NONE = 3'd0,
    IID_RDA  = 3'd2,
    IID_CTO  = 3'd6
  } irq_id_e;

  // threshold for each select code
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // idle limit: three and a half frames of (start + data + stop) bits
  function automatic int unsigned idle_limit(input logic [1:0] len);
    int unsigned bits;
    bits = LEN_MIN + int'(len) + 2;
    return (7 * bits) / 2;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          dropped
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dropped = push && !do_push;
  assign rdata   = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1)); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CW'(DEPTH))); // R1
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (rdata == '0)); // R2
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int unsigned TW = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       tick,
  input  logic [1:0] ch_len,
  output logic       expired
);
  import uart_rxq_pkg::*;

  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  assign limit   = TW'(idle_limit(ch_len));
  assign expired = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart)           cnt <= '0;
    else if (tick && !expired)  cnt <= cnt + 1'b1;
  end

  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired); // R7
endmodule

// File: rtl/rxq_irq_ctl.sv
module rxq_irq_ctl #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [1:0]    trig_sel,
  input  logic          idle_expired,
  input  logic          irq_en,
  output logic          irq,
  output logic [2:0]    irq_id
);
  import uart_rxq_pkg::*;

  logic [CW-1:0] thresh;
  logic          rda_pend, cto_pend;
  irq_id_e       id_sel;

  assign thresh   = CW'(trig_level(trig_sel));
  assign rda_pend = (count >= thresh);
  assign cto_pend = idle_expired && (count != '0) && (count < thresh);

  always_comb begin
    id_sel = IID_NONE;
    if (irq_en) begin
      if (rda_pend)      id_sel = IID_RDA;
      else if (cto_pend) id_sel = IID_CTO;
    end
  end

  assign irq_id = id_sel;
  assign irq    = (id_sel != IID_NONE);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> (!irq && irq_id == 3'd0)); // R5
  AST_RDA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && count >= thresh) |-> (irq_id == 3'd2)); // R6
  AST_CTO_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id == 3'd6) |-> (count != '0 && count < thresh)); // R7
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 6,
  localparam int unsigned DW   = uart_rxq_pkg::CHAR_W,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [1:0]    ch_len,
  input  logic          bit_tick,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  input  logic          rd_pop,
  input  logic          ovr_clr,
  output logic [DW-1:0] rd_data,
  output logic          rx_nonempty,
  output logic          overrun,
  output logic          irq,
  output logic [2:0]    irq_id
);
  import uart_rxq_pkg::*;

  logic [DW-1:0] masked;
  logic [CW-1:0] count;
  logic          empty, dropped, expired, restart;

  // keep bit i only when it lies inside the configured character length
  for (genvar i = 0; i < DW; i++) begin : g_mask
    if (i < int'(LEN_MIN)) begin : g_always
      assign masked[i] = in_data[i];
    end else begin : g_len
      assign masked[i] = in_data[i] && (int'(ch_len) > (i - int'(LEN_MIN)));
    end
  end

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .wdata(masked),
    .pop(rd_pop), .rdata(rd_data), .count(count), .empty(empty),
    .dropped(dropped)
  );

  assign restart = in_valid || (rd_pop && !empty) || empty;

  rxq_idle_timer #(.TW(TW)) i_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(bit_tick),
    .ch_len(ch_len), .expired(expired)
  );

  rxq_irq_ctl #(.CW(CW)) i_irq (
    .clk(clk), .rst_n(rst_n), .count(count), .trig_sel(trig_sel),
    .idle_expired(expired), .irq_en(irq_en), .irq(irq), .irq_id(irq_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (dropped) overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  assign rx_nonempty = !empty;

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> overrun); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun); // R8
  AST_LEN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ch_len == 2'd0) |-> (masked[DW-1:LEN_MIN] == '0)); // R3
endmodule

// File: tb/test_uart_rx_queue.sv
module test_uart_rx_queue;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {ch_len, in_data, expected read value}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'hFF, 8'h1F}, {2'd1, 8'hAA, 8'h2A},
    {2'd2, 8'hC3, 8'h43}, {2'd3, 8'hC3, 8'hC3},
    {2'd0, 8'hE5, 8'h05}, {2'd1, 8'h5A, 8'h1A},
    {2'd2, 8'hFE, 8'h7E}, {2'd3, 8'h01, 8'h01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, bit_tick = 0, irq_en = 0, rd_pop = 0, ovr_clr = 0;
  logic [7:0] in_data = '0;
  logic [1:0] ch_len = 2'd3, trig_sel = 2'd0;
  logic [7:0] rd_data;
  logic rx_nonempty, overrun, irq;
  logic [2:0] irq_id;
  int total = 0, bad = 0;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_queue i_uart_rx_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .ch_len(ch_len), .bit_tick(bit_tick), .trig_sel(trig_sel),
    .irq_en(irq_en), .rd_pop(rd_pop), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .rx_nonempty(rx_nonempty), .overrun(overrun),
    .irq(irq), .irq_id(irq_id)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    in_data = d; in_valid = 1; cyc(); in_valid = 0;
  endtask

  task automatic pop(output logic [7:0] d);
    d = rd_data; rd_pop = 1; cyc(); rd_pop = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bit_tick = 1; cyc(); bit_tick = 0; cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; cyc();
    // reset state
    chk("R2 reset nonempty", rx_nonempty, 0);
    chk("R2 reset rd_data", rd_data, 0);
    chk("R8 reset overrun", overrun, 0);
    chk("R5 reset irq", irq, 0);
    chk("R6 reset irq_id", irq_id, 0);

    // table walk: length masking and order
    for (int v = 0; v < NVEC; v++) begin
      ch_len = VEC[v][17:16]; push(VEC[v][15:8]);
    end
    for (int v = 0; v < NVEC; v++) begin
      pop(got); chk("R3 masked data in order", got, VEC[v][7:0]);
    end
    chk("R2 drained", rx_nonempty, 0);

    // pop while empty
    rd_pop = 1; cyc(); rd_pop = 0;
    chk("R2 empty pop rd_data", rd_data, 0);
    chk("R2 empty pop nonempty", rx_nonempty, 0);
    ch_len = 2'd3; push(8'h77);
    chk("R2 head after empty pop", rd_data, 8'h77);
    pop(got);

    // threshold 4 and enable gating
    trig_sel = 2'd1; irq_en = 1;
    for (int k = 0; k < 3; k++) push(8'h10 + 8'(k));
    chk("R4 below threshold id", irq_id, 0);
    push(8'h13);
    chk("R4 threshold 4 id", irq_id, 2);
    chk("R5 irq with enable", irq, 1);
    irq_en = 0; #1;
    chk("R5 irq masked", irq, 0);
    chk("R5 id masked", irq_id, 0);
    irq_en = 1;

    // idle timeout: 3 held, 8-bit chars -> 35 ticks
    pop(got); chk("R2 first of batch", got, 8'h10);
    ticks(34);
    chk("R7 before limit", irq_id, 0);
    ticks(1);
    chk("R7 timeout id", irq_id, 6);
    chk("R7 timeout irq", irq, 1);
    trig_sel = 2'd0; #1;
    chk("R6 data-ready over timeout", irq_id, 2);
    trig_sel = 2'd1; #1;
    push(8'h14);
    chk("R7 push clears timeout", irq_id, 2);
    pop(got); chk("R2 second of batch", got, 8'h11);
    chk("R7 pop clears timeout", irq_id, 0);
    for (int k = 0; k < 3; k++) pop(got);
    chk("R2 last of batch", got, 8'h14);

    // 5-bit chars: limit 24
    ch_len = 2'd0; push(8'h03);
    ticks(23);
    chk("R7 5-bit before limit", irq_id, 0);
    ticks(1);
    chk("R7 5-bit timeout", irq_id, 6);
    pop(got); ch_len = 2'd3;

    // threshold 14, fill, overrun
    trig_sel = 2'd3;
    for (int k = 0; k < 13; k++) push(8'h30 + 8'(k));
    chk("R4 13 below 14", irq_id, 0);
    push(8'h3D);
    chk("R4 threshold 14 id", irq_id, 2);
    push(8'h3E); push(8'h3F);
    chk("R8 no overrun at full", overrun, 0);
    push(8'hEE);
    chk("R8 overrun set", overrun, 1);
    for (int k = 0; k < 16; k++) begin
      pop(got); chk("R1 full order", got, 8'h30 + 8'(k));
    end
    chk("R1 dropped char absent", rx_nonempty, 0);
    chk("R8 overrun sticky", overrun, 1);
    ovr_clr = 1; cyc(); ovr_clr = 0;
    chk("R8 overrun cleared", overrun, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule